// File: doc/BRIEF.md
# Return-Gated Priority Interrupt Arbiter

This block collects seven interrupt request lines for a small processor core, turns each rising edge into a held pending flag, and offers the core a service-routine vector only at the moment the core retires a subroutine return (either of its two return forms). Outside those return cycles nothing is ever granted. A pending request therefore waits until the running code next returns. The service routine may then freely reuse working registers that only matter between calls.

When a return is signalled and at least one flag is pending, the arbiter raises the take strobe in that same cycle. It picks the lowest-numbered pending line, reports it as a one-hot grant, and drives the stack-memory word address that holds that line's vector. The grant also clears the chosen flag at the next clock edge. Because the grant is combinational on the return strobe, a one-instruction service routine costs only the return itself plus the vector fetch. Each request line passes through a configurable synchronizer before edge detection.

Top module: `irq_ret_arbiter`

## Requirements
- R1: `take_o` is high in exactly those cycles where `ret_i` is high and at least one pending flag is set; it is never high while `ret_i` is low.
- R2: A low-to-high transition of `irq_i[k]` sets pending flag k. With the default two synchronizer stages, a level first sampled high at clock edge n (low at edge n-1) can be taken in the cycle that follows edge n+2.
- R3: When several flags are pending, the grant goes to the lowest bit index (`irq_i[0]` is level 1, highest priority; `irq_i[6]` is level 7, lowest). `grant_o` is one-hot on that index during a take and all zero otherwise.
- R4: During a take, `vec_addr_o` equals 0x08 + (6 - k) for granted index k, giving 0x0E for level 1 and 0x08 for level 7.
- R5: A pending flag stays set through any number of cycles without a take. A line that remains high does not set its flag again.
- R6: A granted flag is cleared at the clock edge ending the take cycle, unless a new rising edge is detected on that line in the same cycle, in which case it stays set.
- R7: Reset (`rst_ni` low) clears all pending flags and sets the edge history as if every line were high. A line already high when reset is released therefore raises no request.
- R8: A request held high across a single sampling clock edge is captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | 7 | Request lines; bit 0 is level 1 (highest) |
| ret_i | input | 1 | High while the core executes a return instruction |
| take_o | output | 1 | Interrupt taken in this return cycle |
| grant_o | output | 7 | One-hot acknowledge of the line being taken |
| vec_addr_o | output | 8 | Stack-memory word address of the vector; zero when nothing is pending |

## Verification
A pending flag that is set or cleared wrongly appears at the ports at the next return cycle. A spurious take or a missing take shows on `take_o` in that cycle, and a wrong winner shows on `grant_o` and `vec_addr_o`. A lost flag is only seen when a return arrives with no other request pending, so the stimulus mixes sparse and dense return strobes. A reference model runs beside the design and compares every cycle, which exposes an error within one return of its cause.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int unsigned IRQ_LEVELS = 7;
  localparam int unsigned IRQ_VEC_W  = 8;
  localparam int unsigned IRQ_SYNC   = 2;
  localparam logic [IRQ_VEC_W-1:0] IRQ_VEC_BASE = 8'h08;
endpackage

// File: rtl/irq_in_sync.sv
module irq_in_sync #(
  parameter int unsigned N      = 7,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] d_i,
  output logic [N-1:0] q_o
);
  generate
    if (STAGES == 0) begin : g_bypass
      // inputs already synchronous to clk_i
      assign q_o = d_i;
    end else begin : g_chain
      logic [STAGES-1:0][N-1:0] chain_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          chain_q <= '1;
        end else begin
          chain_q[0] <= d_i;
          for (int s = 1; s < STAGES; s++) chain_q[s] <= chain_q[s-1];
        end
      end
      assign q_o = chain_q[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/irq_edge_pend.sv
module irq_edge_pend #(
  parameter int unsigned N = 7
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] lvl_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] edge_o,
  output logic [N-1:0] pend_o
);
  logic [N-1:0] prev_q;
  logic [N-1:0] pend_q;

  assign edge_o = lvl_i & ~prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '1; // high history: no edge from a line already up
      pend_q <= '0;
    end else begin
      prev_q <= lvl_i;
      pend_q <= (pend_q & ~clr_i) | edge_o;
    end
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int unsigned N     = 7,
  parameter int unsigned VEC_W = 8,
  parameter logic [VEC_W-1:0] VEC_BASE = 8'h08
) (
  input  logic [N-1:0]     pend_i,
  input  logic             ret_i,
  output logic             take_o,
  output logic [N-1:0]     grant_o,
  output logic [VEC_W-1:0] vec_o
);
  localparam int unsigned IDX_W = (N > 1) ? $clog2(N) : 1;

  logic [N-1:0]     sel;
  logic [IDX_W-1:0] idx;
  logic             found;

  always_comb begin
    sel   = '0;
    idx   = '0;
    found = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (pend_i[i] && !found) begin
        found  = 1'b1;
        sel[i] = 1'b1;
        idx    = IDX_W'(i);
      end
    end
  end

  assign take_o  = ret_i & found;
  assign grant_o = take_o ? sel : '0;
  assign vec_o   = found ? (VEC_BASE + VEC_W'(N - 1) - VEC_W'(idx)) : '0;
endmodule

// File: rtl/irq_ret_arbiter.sv
module irq_ret_arbiter
  import irq_pkg::*;
#(
  parameter int unsigned LEVELS = IRQ_LEVELS,
  parameter int unsigned SYNC   = IRQ_SYNC,
  parameter int unsigned VEC_W  = IRQ_VEC_W,
  parameter logic [VEC_W-1:0] VEC_BASE = IRQ_VEC_BASE
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [LEVELS-1:0] irq_i,
  input  logic              ret_i,
  output logic              take_o,
  output logic [LEVELS-1:0] grant_o,
  output logic [VEC_W-1:0]  vec_addr_o
);
  logic [LEVELS-1:0] lvl_w;
  logic [LEVELS-1:0] edge_w;
  logic [LEVELS-1:0] pend_w;
  logic [LEVELS-1:0] grant_w;

  irq_in_sync #(.N(LEVELS), .STAGES(SYNC)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (irq_i),
    .q_o   (lvl_w)
  );

  irq_edge_pend #(.N(LEVELS)) i_pend (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .lvl_i (lvl_w),
    .clr_i (grant_w),
    .edge_o(edge_w),
    .pend_o(pend_w)
  );

  irq_prio_pick #(.N(LEVELS), .VEC_W(VEC_W), .VEC_BASE(VEC_BASE)) i_pick (
    .pend_i (pend_w),
    .ret_i  (ret_i),
    .take_o (take_o),
    .grant_o(grant_w),
    .vec_o  (vec_addr_o)
  );

  assign grant_o = grant_w;
endmodule

// File: rtl/irq_ret_arbiter_chk.sv
module irq_ret_arbiter_chk #(
  parameter int unsigned LEVELS = 7,
  parameter int unsigned VEC_W  = 8,
  parameter logic [VEC_W-1:0] VEC_BASE = 8'h08
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ret_i,
  input logic              take_o,
  input logic [LEVELS-1:0] grant_o,
  input logic [VEC_W-1:0]  vec_addr_o,
  input logic [LEVELS-1:0] pend_i,
  input logic [LEVELS-1:0] edge_i
);
  assert_take_needs_ret_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |-> ret_i);

  assert_take_when_pending_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ret_i && (pend_i != '0)) |-> take_o);

  assert_edge_sets_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edge_i != '0) |=> ((pend_i & $past(edge_i)) == $past(edge_i)));

  assert_grant_onehot_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |-> ($countones(grant_o) == 1 && (grant_o & pend_i) != '0));

  assert_no_idle_grant_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !take_o |-> (grant_o == '0));

  assert_lowest_wins_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |-> ((pend_i & (grant_o - 1'b1)) == '0));

  assert_vec_range_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |-> (vec_addr_o >= VEC_BASE && vec_addr_o <= VEC_BASE + VEC_W'(LEVELS - 1)));

  assert_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ret_i |=> (($past(pend_i) & ~pend_i) == '0));

  assert_clear_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |=> ((pend_i & $past(grant_o) & ~$past(edge_i)) == '0));
endmodule

bind irq_ret_arbiter irq_ret_arbiter_chk #(
  .LEVELS(LEVELS), .VEC_W(VEC_W), .VEC_BASE(VEC_BASE)
) i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .ret_i     (ret_i),
  .take_o    (take_o),
  .grant_o   (grant_o),
  .vec_addr_o(vec_addr_o),
  .pend_i    (pend_w),
  .edge_i    (edge_w)
);

// File: tb/test_irq_ret_arbiter.sv
module test_irq_ret_arbiter;
  localparam int L = 7;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic [L-1:0] irq_i = '0;
  logic         ret_i = 1'b0;
  logic         take_o;
  logic [L-1:0] grant_o;
  logic [7:0]   vec_addr_o;

  int n_chk = 0;
  int n_fail = 0;
  string tag = "R7";

  // bench reference: sample history and pending flags
  logic [L-1:0] h1, h2, h3, m_pend;

  always #4 clk_i = ~clk_i;

  irq_ret_arbiter i_irq_ret_arbiter (
    .clk_i(clk_i), .rst_ni(rst_ni), .irq_i(irq_i), .ret_i(ret_i),
    .take_o(take_o), .grant_o(grant_o), .vec_addr_o(vec_addr_o)
  );

  function automatic logic [L-1:0] lowest(input logic [L-1:0] v);
    for (int i = 0; i < L; i++) if (v[i]) return L'(1) << i;
    return '0;
  endfunction

  function automatic logic [7:0] vec_of(input logic [L-1:0] oh);
    for (int i = 0; i < L; i++) if (oh[i]) return 8'(8 + 6 - i);
    return 8'h00;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    h1 = '1; h2 = '1; h3 = '1; m_pend = '0;
  endtask

  // one cycle: drive at negedge, check outputs, then advance the model
  task automatic step(input logic [L-1:0] irq, input logic ret);
    logic [L-1:0] e_grant, edge_now;
    @(negedge clk_i);
    irq_i = irq;
    ret_i = ret;
    #1;
    e_grant = ret ? lowest(m_pend) : '0;
    check({"R1/", tag}, int'(take_o), int'(e_grant != '0));
    check({"R3/", tag}, int'(grant_o), int'(e_grant));
    if (e_grant != '0) check({"R4/", tag}, int'(vec_addr_o), int'(vec_of(e_grant)));
    @(posedge clk_i);
    edge_now = h2 & ~h3;
    m_pend = (m_pend & ~e_grant) | edge_now;
    h3 = h2; h2 = h1; h1 = irq;
  endtask

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [L-1:0] cur;
    void'($urandom(32'h1d5a_0c31));
    model_reset();
    // R7: line 0 high across reset must not create a request
    irq_i = 7'b000_0001;
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    rst_ni = 1'b1;
    #1;
    check("R7", int'(take_o), 0);
    check("R7", int'(grant_o), 0);
    for (int c = 0; c < 6; c++) step(7'b000_0001, 1'b1);
    check("R7", int'(take_o), 0);

    // R8/R2: single-clock pulse on level 7, taken three edges later
    tag = "R8";
    step(7'b100_0000, 1'b0);
    step(7'b000_0000, 1'b0);
    step(7'b000_0000, 1'b0);
    step(7'b000_0000, 1'b1);
    tag = "R2";
    step(7'b000_0000, 1'b0);

    // R3/R5: levels 3 and 5 together, held high, many cycles without return
    tag = "R5";
    for (int c = 0; c < 8; c++) step(7'b001_0100, 1'b0);
    tag = "R3";
    step(7'b001_0100, 1'b1); // level 3, vector 0x0C
    step(7'b001_0100, 1'b1); // level 5, vector 0x0A
    tag = "R5";
    step(7'b001_0100, 1'b1); // held lines raise nothing further
    check("R5", int'(take_o), 0);

    // R6: new edge on level 2 in the very cycle it is granted
    tag = "R6";
    step(7'b000_0010, 1'b0);
    step(7'b000_0000, 1'b0);
    step(7'b000_0000, 1'b0);
    step(7'b000_0010, 1'b0); // rise sampled here
    step(7'b000_0010, 1'b0);
    step(7'b000_0010, 1'b1); // edge detected now, grant of older flag
    step(7'b000_0010, 1'b1); // flag still set: taken again
    step(7'b000_0010, 1'b1); // now empty

    // R4: every level alone, checking its vector
    tag = "R4";
    for (int k = 0; k < L; k++) begin
      step(L'(1) << k, 1'b0);
      step('0, 1'b0);
      step('0, 1'b0);
      step('0, 1'b1);
    end

    // random mix of toggles and returns
    tag = "R2";
    cur = '0;
    for (int c = 0; c < 4000; c++) begin
      for (int b = 0; b < L; b++) if (($urandom % 6) == 0) cur[b] = ~cur[b];
      step(cur, (c % 500 < 250) ? (($urandom % 8) == 0) : (($urandom % 2) == 0));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule